// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. Software programs it through a small write-only register bus: one control register holds the analog channel select, a conversion trigger bit and an active-low power-down bit, and one configuration register holds a 3-bit conversion-rate select. From the system clock the block derives a conversion tick, drives a trial code to the external DAC, reads back a single comparator bit, and resolves the result one bit per tick, from the most significant bit down to the least significant.

A conversion is armed by writing the trigger bit to one and is launched when a later write clears it. While it runs, an active-low completion flag reads one. The flag drops to zero when the last bit is resolved and the result register is updated. Writing a different channel, or setting the trigger again, abandons any conversion in progress and forces the flag back to one until the next trigger pulse completes a fresh conversion.

Register map: address 0 is control, with bits [2:0] for the channel, bit 3 for the trigger and bit 4 for the power-down bit. Address 1 is configuration, with bits [2:0] for the rate select. Writes to other addresses are ignored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, eoc_n is 1, chan_sel is 0, result is 0 and dac_code is 0. The power-down bit resets to 1, the rate select to 000 and the trigger bit to 0.
- R2: Rate select 000 divides the system clock by 2, 001 by 8 and 010 by 32. A conversion takes exactly 10 ticks, so eoc_n falls 10×divisor clock edges after the edge that takes the trigger-clearing write.
- R3: Rate select values 011 and 100 to 111 stop the conversion tick. A started conversion holds with eoc_n at 1 and resumes once a valid rate is written.
- R4: While the power-down bit is 1, no conversion tick occurs and a pending conversion holds. Clearing the bit lets it continue.
- R5: chan_sel always shows the channel field of the control register.
- R6: A control write whose channel field differs from the current channel forces eoc_n to 1 on the next cycle. A write of the same channel leaves eoc_n unchanged.
- R7: A control write with the trigger bit at 1 forces eoc_n to 1 and starts nothing. A following write that clears the trigger begins a conversion.
- R8: The result equals the code found by binary search with a comparator that reads 1 when the input is at or above dac_code. It is written only when the last bit resolves, at the same edge where eoc_n falls.
- R9: Setting the trigger while a conversion runs abandons it. The result keeps its previous value and eoc_n stays 1 until a new pulse completes.
- R10: The first trial code after a start is 10'h200, and each tick resolves the next lower bit.
- R11: A channel change during a conversion abandons it. eoc_n stays 1 and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 configuration) |
| wr_data | input | 8 | Register write data |
| cmp_in | input | 1 | Comparator output, 1 when the analog input is at or above the DAC level |
| chan_sel | output | 3 | Channel select to the analog multiplexer |
| dac_code | output | 10 | Trial code to the DAC, 0 when idle |
| result | output | 10 | Last completed conversion result |
| eoc_n | output | 1 | Active-low conversion-complete flag |

## Verification
The hardest states to reach are the ones where a conversion is parked partway through. These include a conversion that stalls on an undefined rate select or on power-down, and one abandoned by a trigger re-write or a channel change after a few ticks. The bench reaches them by starting a conversion against a behavioural comparator and then changing the configuration or control register after a known number of cycles. It then waits well past a full conversion time before checking that the flag and the result have not moved, and that a later resume or restart produces the exact timing and code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int CH_W    = 3;
    localparam int PS_W    = 3;
    localparam int RES_W   = 10;
    localparam int MAX_DIV = 32;
    localparam int DIV_W   = $clog2(MAX_DIV) + 1;
    localparam int IDX_W   = $clog2(RES_W);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;

    typedef enum logic [PS_W-1:0] {
        RATE_DIV2  = 3'b000,
        RATE_DIV8  = 3'b001,
        RATE_DIV32 = 3'b010
    } rate_e;

    // control register layout: [4] power-down, [3] trigger, [2:0] channel
    typedef struct packed {
        logic            pwr_dn;
        logic            trig;
        logic [CH_W-1:0] chan;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // clock divisor for a rate select; 0 means the tick is stopped
    function automatic logic [DIV_W-1:0] rate_div(input logic [PS_W-1:0] ps);
        case (ps)
            RATE_DIV2:  rate_div = DIV_W'(2);
            RATE_DIV8:  rate_div = DIV_W'(8);
            RATE_DIV32: rate_div = DIV_W'(MAX_DIV);
            default:    rate_div = '0;
        endcase
    endfunction

endpackage

// File: rtl/adc_regs.sv
module adc_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [PS_W-1:0]   rate_q,
    output logic              start_conv,
    output logic              abandon
);

    ctrl_t wr_ctrl;
    logic  ctrl_wr;
    logic  cfg_wr;

    assign wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);

    // a trigger falling from 1 to 0 launches a conversion
    assign start_conv = ctrl_wr && ctrl_q.trig && !wr_ctrl.trig;
    // setting the trigger or moving the channel invalidates the flag
    assign abandon    = ctrl_wr && (wr_ctrl.trig || (wr_ctrl.chan != ctrl_q.chan));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{pwr_dn: 1'b1, trig: 1'b0, chan: '0};
            rate_q <= RATE_DIV2;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_ctrl;
            if (cfg_wr)  rate_q <= wr_data[PS_W-1:0];
        end
    end

endmodule

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] rate,
    output logic            tick
);

    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] cnt;

    assign div  = rate_div(rate);
    assign tick = run && (div != '0) && (cnt == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || div == '0) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R2: smallest divisor is 2, so ticks are never back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/adc_sar.sv
module adc_sar
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_conv,
    input  logic             abandon,
    input  logic             tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result,
    output logic             eoc_n
);

    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] sar;
    logic [RES_W-1:0] bit_m;
    logic [RES_W-1:0] next_sar;

    assign bit_m    = RES_W'(1) << idx;
    assign trial    = busy ? (sar | bit_m) : '0;
    assign next_sar = cmp_in ? (sar | bit_m) : sar;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            sar    <= '0;
            result <= '0;
            eoc_n  <= 1'b1;
        end else if (start_conv) begin
            busy  <= 1'b1;
            idx   <= IDX_W'(RES_W - 1);
            sar   <= '0;
            eoc_n <= 1'b1;
        end else if (abandon) begin
            busy  <= 1'b0;
            sar   <= '0;
            eoc_n <= 1'b1;
        end else if (busy && tick) begin
            if (idx == '0) begin
                result <= next_sar;
                busy   <= 1'b0;
                sar    <= '0;
                eoc_n  <= 1'b0;
            end else begin
                sar <= next_sar;
                idx <= idx - IDX_W'(1);
            end
        end
    end

    // R10: a fresh conversion tries the MSB first
    a_r10_msb_first: assert property (@(posedge clk) disable iff (rst)
        start_conv |=> (trial == (RES_W'(1) << (RES_W - 1))));

    // R8: completion is only reported out of a running conversion
    a_r8_done_from_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> $past(busy));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmp_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic [RES_W-1:0]  dac_code,
    output logic [RES_W-1:0]  result,
    output logic              eoc_n
);

    ctrl_t           ctrl_q;
    logic [PS_W-1:0] rate_q;
    logic            start_conv;
    logic            abandon;
    logic            busy;
    logic            tick;

    adc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q),
        .rate_q     (rate_q),
        .start_conv (start_conv),
        .abandon    (abandon)
    );

    adc_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && !ctrl_q.pwr_dn),
        .rate (rate_q),
        .tick (tick)
    );

    adc_sar u_sar (
        .clk        (clk),
        .rst        (rst),
        .start_conv (start_conv),
        .abandon    (abandon),
        .tick       (tick),
        .cmp_in     (cmp_in),
        .busy       (busy),
        .trial      (dac_code),
        .result     (result),
        .eoc_n      (eoc_n)
    );

    assign chan_sel = ctrl_q.chan;

    // R6: a new channel value invalidates the flag
    a_r6_chan_change: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[CH_W-1:0] != chan_sel) |=> eoc_n);

    // R7: setting the trigger flags and parks the converter
    a_r7_trig_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[CH_W+1-1]) |=> (eoc_n && dac_code == '0));

    // R4: powered down and untouched, nothing moves
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.pwr_dn && !wr_en) |=> ($stable(dac_code) && $stable(eoc_n)));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       cmp_in;
    logic [2:0] chan_sel;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       eoc_n;
    logic [9:0] vin;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    // behavioural comparator
    assign cmp_in = (vin >= dac_code);

    adc_seq_ctrl dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmp_in   (cmp_in),
        .chan_sel (chan_sel),
        .dac_code (dac_code),
        .result   (result),
        .eoc_n    (eoc_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic pd, input logic tr, input logic [2:0] ch);
        return {3'b000, pd, tr, ch};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts edges until eoc_n falls (bounded)
    task automatic wait_done(output int n);
        n = 0;
        while (eoc_n && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic pulse(input logic [2:0] ch);
        wr(2'd0, ctl(1'b0, 1'b1, ch));
        wr(2'd0, ctl(1'b0, 1'b0, ch));
    endtask

    task automatic t_reset();
        chk("R1 eoc_n", eoc_n, 1);
        chk("R1 chan_sel", chan_sel, 0);
        chk("R1 result", result, 0);
        chk("R1 dac_code", dac_code, 0);
        // trigger at 0 after reset: clearing it does not start anything
        wr(2'd0, ctl(1'b0, 1'b0, 3'd0));
        idle(40);
        chk("R1 no start", dac_code, 0);
    endtask

    task automatic t_convert(input logic [2:0] ps, input int div, input logic [9:0] v, input logic [2:0] ch);
        int n;
        vin = v;
        wr(2'd1, {5'd0, ps});
        pulse(ch);
        chk("R10 first trial", dac_code, 10'h200);
        chk("R5 chan_sel", chan_sel, ch);
        wait_done(n);
        chk("R2 cycles", n, 10 * div);
        chk("R8 result", result, v);
    endtask

    task automatic t_second_trial();
        int n;
        vin = 10'd100;
        wr(2'd1, 8'd1);
        pulse(3'd1);
        idle(8);
        // after the first tick the MSB is rejected, so bit 8 is tried
        chk("R10 second trial", dac_code, 10'h100);
        wait_done(n);
        chk("R8 result 100", result, 100);
    endtask

    task automatic t_stopped(input logic [2:0] ps);
        int n;
        vin = 10'd777;
        wr(2'd1, {5'd0, ps});
        pulse(3'd2);
        idle(400);
        chk("R3 stalled eoc_n", eoc_n, 1);
        chk("R3 stalled trial", dac_code, 10'h200);
        wr(2'd1, 8'd0);
        wait_done(n);
        chk("R3 resumed cycles", n, 20);
        chk("R3 resumed result", result, 777);
    endtask

    task automatic t_powerdown();
        int n;
        vin = 10'd45;
        wr(2'd1, 8'd0);
        wr(2'd0, ctl(1'b1, 1'b1, 3'd4));
        wr(2'd0, ctl(1'b1, 1'b0, 3'd4));
        idle(300);
        chk("R4 off eoc_n", eoc_n, 1);
        chk("R4 off trial", dac_code, 10'h200);
        wr(2'd0, ctl(1'b0, 1'b0, 3'd4));
        wait_done(n);
        chk("R4 resumed cycles", n, 20);
        chk("R4 resumed result", result, 45);
    endtask

    task automatic t_chan_flag();
        t_convert(3'd0, 2, 10'd600, 3'd5);
        wr(2'd0, ctl(1'b0, 1'b0, 3'd5));
        chk("R6 same chan keeps", eoc_n, 0);
        wr(2'd0, ctl(1'b0, 1'b0, 3'd6));
        chk("R6 new chan flags", eoc_n, 1);
        chk("R5 chan follows", chan_sel, 6);
        idle(100);
        chk("R6 stays flagged", eoc_n, 1);
        chk("R6 result kept", result, 600);
    endtask

    task automatic t_trig_set();
        t_convert(3'd0, 2, 10'd222, 3'd6);
        wr(2'd0, ctl(1'b0, 1'b1, 3'd6));
        chk("R7 set flags", eoc_n, 1);
        idle(60);
        chk("R7 nothing started", dac_code, 0);
    endtask

    task automatic t_abort_trig();
        int n;
        t_convert(3'd1, 8, 10'd300, 3'd3);
        vin = 10'd900;
        pulse(3'd3);
        idle(24);
        wr(2'd0, ctl(1'b0, 1'b1, 3'd3));
        idle(400);
        chk("R9 abort eoc_n", eoc_n, 1);
        chk("R9 abort result", result, 300);
        wr(2'd0, ctl(1'b0, 1'b0, 3'd3));
        wait_done(n);
        chk("R9 restart cycles", n, 80);
        chk("R9 restart result", result, 900);
    endtask

    task automatic t_abort_chan();
        t_convert(3'd0, 2, 10'd511, 3'd0);
        vin = 10'd10;
        pulse(3'd0);
        idle(6);
        wr(2'd0, ctl(1'b0, 1'b0, 3'd7));
        idle(200);
        chk("R11 chan abort eoc_n", eoc_n, 1);
        chk("R11 chan abort result", result, 511);
        chk("R11 idle trial", dac_code, 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; vin = '0;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_convert(3'd0, 2, 10'd0, 3'd1);
        t_convert(3'd1, 8, 10'd1023, 3'd2);
        t_convert(3'd2, 32, 10'd341, 3'd7);
        t_convert(3'd0, 2, 10'd682, 3'd3);
        t_convert(3'd0, 2, 10'd512, 3'd4);
        t_second_trial();
        t_stopped(3'd3);
        t_stopped(3'd6);
        t_powerdown();
        t_chan_flag();
        t_trig_set();
        t_abort_trig();
        t_abort_chan();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule